// File: doc/BRIEF.md
# Telemetry Frame Lock Checker

This block sits on the receive side of a serial telemetry link. A bank of free-running cores shares that link, and each core reports its state together with a global iteration counter. The block takes the received byte stream and finds the frame boundaries. It then decides, frame by frame, whether each frame is trustworthy. A frame is trusted only when its counter has moved forward by exactly the bank size since the last frame from the same core. This rule catches stale bytes, misalignment and dropped frames without needing any other context.

At the start of a capture the block sees junk: bytes left in buffers and frames cut in half. It rejects these until two well-formed frames in a row pass the counter test. At that point it declares the stream locked, and the lock stays set until reset. Any rejection after lock is a real fault, not part of the start-up clean-up, so it raises a sticky anomaly flag. Two running totals count the accepted and rejected frames.

Top module: `frame_lock_checker`

## Requirements
- R1: A frame has ten bytes. It starts with the sync byte 0xA5, then one core index byte, then the counter in four bytes with the most significant byte first, then the state value in three bytes with the most significant byte first. It ends with a check byte, which is the sum modulo 256 of the eight bytes between the sync byte and the check byte. Any byte that arrives while the parser is searching and is not 0xA5 is ignored.
- R2: A frame whose check byte is wrong raises neither strobe and changes no stored state. The search for a sync byte restarts with the byte that follows the check byte.
- R3: A well-formed frame is accepted when its core already has a stored counter and the frame's counter minus that stored counter, taken modulo 2^32, equals 49. This holds across a carry into bit 24 and across a wrap from 0xFFFFFFFF to 0.
- R4: The first well-formed frame for a core after reset is rejected. Its counter becomes that core's stored counter.
- R5: Every well-formed frame with a valid core index replaces that core's stored counter with its own counter, whether the frame is accepted or rejected.
- R6: A frame whose core index is 49 or higher is rejected and leaves every core's stored counter unchanged.
- R7: The lock flag rises on an accepted frame when the previous well-formed frame was also accepted. Once set, it never falls before reset.
- R8: A rejection while the stream is locked sets a sticky anomaly flag. A rejection before lock does not set it.
- R9: The accept total and the reject total each increase by one for every accept strobe and every reject strobe.
- R10: For each well-formed frame, exactly one of the accept strobe and the reject strobe pulses for a single cycle. The pulse comes two clock edges after the edge that samples the check byte. With the accept strobe, the outputs carry that frame's core index, counter and state value.
- R11: Reset clears the lock flag, the anomaly flag, both totals and every core's stored-counter valid bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Marks in_byte as carrying a received byte |
| in_byte | input | 8 | Received byte |
| acc_stb | output | 1 | One-cycle pulse: frame accepted |
| acc_core | output | 8 | Core index of the last accepted frame |
| acc_cnt | output | 32 | Counter of the last accepted frame |
| acc_x | output | 24 | State value of the last accepted frame |
| rej_stb | output | 1 | One-cycle pulse: frame rejected |
| locked | output | 1 | Sticky stream lock flag |
| anomaly | output | 1 | Sticky flag: rejection after lock |
| acc_total | output | 32 | Number of accepted frames |
| rej_total | output | 32 | Number of rejected frames |

## Verification
Every verdict comes out two edges after the check byte is sampled. The first edge registers the parsed frame. The second edge reads the core's stored counter and registers the strobes, the fields, the totals and the flags. The bench drives bytes on falling edges and reads each verdict on the second falling edge after the check byte. It reads the next falling edge as well, to confirm that the strobe has dropped again. A frame with a bad check byte is checked at the same point to confirm that neither strobe fired, and a later frame then shows that the stored counter was left unchanged.

// File: rtl/fl_pkg.sv
// Shared constants and types for the frame lock checker.
// Assumes byte-wide input and a fixed sync byte value.
package fl_pkg;
    localparam logic [7:0] SYNC_BYTE = 8'hA5;

    typedef enum logic {
        PS_HUNT = 1'b0,
        PS_BODY = 1'b1
    } parse_state_t;
endpackage

// File: rtl/fl_parser.sv
// Frame parser. It hunts for the sync byte, then collects the body bytes
// (core index, counter, state value) and compares a running mod-256 sum
// with the check byte. A good frame gives a one-cycle frm_valid with its
// fields. A bad frame is dropped, and the hunt restarts at the next byte.
// Assumes CNT_W and X_W are multiples of 8.
module fl_parser
    import fl_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int X_W   = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_byte,
    output logic             frm_valid,
    output logic [7:0]       frm_core,
    output logic [CNT_W-1:0] frm_cnt,
    output logic [X_W-1:0]   frm_x
);
    localparam int BODY_BYTES = 1 + CNT_W / 8 + X_W / 8;
    localparam int BODY_W     = BODY_BYTES * 8;
    localparam int IDX_W      = $clog2(BODY_BYTES + 1);

    parse_state_t      state;
    logic [IDX_W-1:0]  idx;
    logic [7:0]        sum;
    logic [BODY_W-1:0] body;

    // Byte-level frame state machine with running checksum.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= PS_HUNT;
            idx       <= '0;
            sum       <= '0;
            frm_valid <= 1'b0;
        end else begin
            frm_valid <= 1'b0;
            if (in_valid) begin
                case (state)
                    PS_HUNT: begin
                        if (in_byte == SYNC_BYTE) begin
                            state <= PS_BODY;
                            idx   <= '0;
                            sum   <= '0;
                        end
                    end
                    default: begin
                        if (idx < IDX_W'(BODY_BYTES)) begin
                            idx <= idx + 1'b1;
                            sum <= sum + in_byte;
                        end else begin
                            frm_valid <= (in_byte == sum);
                            state     <= PS_HUNT;
                        end
                    end
                endcase
            end
        end
    end

    // Body shift register, filled most significant byte first.
    always_ff @(posedge clk) begin
        if (in_valid && state == PS_BODY && idx < IDX_W'(BODY_BYTES))
            body <= {body[BODY_W-9:0], in_byte};
    end

    // Field slicing of the collected body.
    always_comb begin
        frm_core = body[BODY_W-1 -: 8];
        frm_cnt  = body[X_W +: CNT_W];
        frm_x    = body[0 +: X_W];
    end
endmodule

// File: rtl/fl_judge.sv
// Per-core delta judge. It keeps the last counter seen for each core plus a
// valid bit. It accepts a frame whose counter advanced by exactly DELTA
// (modulo 2^CNT_W), and it tracks lock, anomaly and the totals.
// Assumes frm_valid pulses for one cycle per well-formed frame.
module fl_judge #(
    parameter int NUM_CORES = 49,
    parameter int CNT_W     = 32,
    parameter int X_W       = 24,
    parameter int DELTA     = 49,
    parameter int STAT_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frm_valid,
    input  logic [7:0]        frm_core,
    input  logic [CNT_W-1:0]  frm_cnt,
    input  logic [X_W-1:0]    frm_x,
    output logic              acc_stb,
    output logic [7:0]        acc_core,
    output logic [CNT_W-1:0]  acc_cnt,
    output logic [X_W-1:0]    acc_x,
    output logic              rej_stb,
    output logic              locked,
    output logic              anomaly,
    output logic [STAT_W-1:0] acc_total,
    output logic [STAT_W-1:0] rej_total
);
    localparam int               ID_W    = $clog2(NUM_CORES);
    localparam logic [7:0]       NCORE_B = 8'(NUM_CORES);
    localparam logic [CNT_W-1:0] DELTA_C = CNT_W'(DELTA);

    logic [CNT_W-1:0]     last_cnt [NUM_CORES];
    logic [NUM_CORES-1:0] seen;
    logic                 prev_acc;
    logic                 id_ok;
    logic [ID_W-1:0]      cidx;
    logic [CNT_W-1:0]     prev_cnt;
    logic [CNT_W-1:0]     delta;
    logic                 hit;

    // Verdict for the frame now presented.
    always_comb begin
        id_ok    = frm_core < NCORE_B;
        cidx     = frm_core[ID_W-1:0];
        prev_cnt = id_ok ? last_cnt[cidx] : '0;
        delta    = frm_cnt - prev_cnt;
        hit      = id_ok && seen[cidx] && (delta == DELTA_C);
    end

    // One stored counter per core, replaced by every well-formed frame.
    for (genvar g = 0; g < NUM_CORES; g++) begin : g_core
        always_ff @(posedge clk) begin
            if (frm_valid && id_ok && cidx == ID_W'(g))
                last_cnt[g] <= frm_cnt;
        end
    end

    // Valid bits, strobes, lock, anomaly and totals.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen      <= '0;
            prev_acc  <= 1'b0;
            acc_stb   <= 1'b0;
            rej_stb   <= 1'b0;
            locked    <= 1'b0;
            anomaly   <= 1'b0;
            acc_total <= '0;
            rej_total <= '0;
        end else begin
            acc_stb <= 1'b0;
            rej_stb <= 1'b0;
            if (frm_valid) begin
                if (id_ok)
                    seen[cidx] <= 1'b1;
                if (hit) begin
                    acc_stb   <= 1'b1;
                    acc_total <= acc_total + 1'b1;
                    prev_acc  <= 1'b1;
                    if (prev_acc)
                        locked <= 1'b1;
                end else begin
                    rej_stb   <= 1'b1;
                    rej_total <= rej_total + 1'b1;
                    prev_acc  <= 1'b0;
                    if (locked)
                        anomaly <= 1'b1;
                end
            end
        end
    end

    // Field capture of the accepted frame.
    always_ff @(posedge clk) begin
        if (frm_valid && hit) begin
            acc_core <= frm_core;
            acc_cnt  <= frm_cnt;
            acc_x    <= frm_x;
        end
    end
endmodule

// File: rtl/frame_lock_checker.sv
// Top level: the byte parser followed by the per-core delta judge.
// Assumes in_valid marks each received byte for exactly one cycle.
module frame_lock_checker #(
    parameter int NUM_CORES = 49,
    parameter int CNT_W     = 32,
    parameter int X_W       = 24,
    parameter int DELTA     = 49,
    parameter int STAT_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [7:0]        in_byte,
    output logic              acc_stb,
    output logic [7:0]        acc_core,
    output logic [CNT_W-1:0]  acc_cnt,
    output logic [X_W-1:0]    acc_x,
    output logic              rej_stb,
    output logic              locked,
    output logic              anomaly,
    output logic [STAT_W-1:0] acc_total,
    output logic [STAT_W-1:0] rej_total
);
    logic             frm_valid;
    logic [7:0]       frm_core;
    logic [CNT_W-1:0] frm_cnt;
    logic [X_W-1:0]   frm_x;

    fl_parser #(.CNT_W(CNT_W), .X_W(X_W)) u_parser (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .frm_valid(frm_valid), .frm_core(frm_core), .frm_cnt(frm_cnt),
        .frm_x(frm_x)
    );

    fl_judge #(.NUM_CORES(NUM_CORES), .CNT_W(CNT_W), .X_W(X_W),
               .DELTA(DELTA), .STAT_W(STAT_W)) u_judge (
        .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid),
        .frm_core(frm_core), .frm_cnt(frm_cnt), .frm_x(frm_x),
        .acc_stb(acc_stb), .acc_core(acc_core), .acc_cnt(acc_cnt),
        .acc_x(acc_x), .rej_stb(rej_stb), .locked(locked),
        .anomaly(anomaly), .acc_total(acc_total), .rej_total(rej_total)
    );
endmodule

// File: rtl/fl_checker.sv
// Property checker for frame_lock_checker, attached through bind.
// Assumes the synchronous active-low reset of the checked block.
module fl_checker #(
    parameter int STAT_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_stb,
    input logic              rej_stb,
    input logic              locked,
    input logic              anomaly,
    input logic [STAT_W-1:0] acc_total,
    input logic [STAT_W-1:0] rej_total
);
    assert_one_verdict_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_stb && rej_stb));

    assert_lock_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(locked));

    assert_anomaly_needs_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
        anomaly |-> locked);

    assert_anomaly_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(anomaly));

    assert_rej_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rej_stb |-> rej_total == $past(rej_total) + STAT_W'(1));

    assert_acc_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
        acc_stb |-> acc_total == $past(acc_total) + STAT_W'(1));

    assert_acc_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_stb |-> $stable(acc_total));
endmodule

bind frame_lock_checker fl_checker #(.STAT_W(STAT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .acc_stb(acc_stb), .rej_stb(rej_stb),
    .locked(locked), .anomaly(anomaly), .acc_total(acc_total),
    .rej_total(rej_total)
);

// File: tb/frame_lock_checker_tb.sv
module frame_lock_checker_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = '0;
    logic        acc_stb, rej_stb, locked, anomaly;
    logic [7:0]  acc_core;
    logic [31:0] acc_cnt, acc_total, rej_total;
    logic [23:0] acc_x;
    int          n_run = 0;
    int          n_fail = 0;
    int          exp_acc_n = 0;
    int          exp_rej_n = 0;

    always #2.5 clk = ~clk;

    frame_lock_checker u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .acc_stb(acc_stb), .acc_core(acc_core), .acc_cnt(acc_cnt),
        .acc_x(acc_x), .rej_stb(rej_stb), .locked(locked),
        .anomaly(anomaly), .acc_total(acc_total), .rej_total(rej_total)
    );

    typedef struct packed {
        logic [7:0]  core;
        logic [31:0] cnt;
        logic [23:0] x;
        logic        bad;
        logic        acc;
        logic        rej;
        logic        lock;
        logic        anom;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{8'd0,  32'd100,        24'h000011, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R4 prime
        '{8'd1,  32'd200,        24'h000022, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R4 prime
        '{8'd2,  32'hFFFFFFF0,   24'h000033, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R4 prime
        '{8'd48, 32'h00FFFFDF,   24'h000044, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R4 prime
        '{8'd0,  32'd149,        24'h123456, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}, // R3, no lock yet R7
        '{8'd1,  32'd249,        24'hABCDEF, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0}, // R7 lock
        '{8'd2,  32'h00000021,   24'h0F0F0F, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0}, // R3 wrap
        '{8'd48, 32'h01000010,   24'h49DE3E, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0}, // R3 2^24 carry
        '{8'd0,  32'd198,        24'h000055, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0}, // R2 bad check
        '{8'd0,  32'd198,        24'h000066, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0}, // R2 table untouched
        '{8'd1,  32'd300,        24'h000077, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1}, // R8 anomaly
        '{8'd1,  32'd349,        24'h000088, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1}  // R5 replaced
    };

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Drives one frame; returns on the falling edge where the verdict is due (R10).
    task automatic send(input logic [7:0] core, input logic [31:0] cnt,
                        input logic [23:0] x, input logic bad);
        logic [7:0] b [10];
        logic [7:0] s;
        b[0] = 8'hA5; b[1] = core;
        b[2] = cnt[31:24]; b[3] = cnt[23:16]; b[4] = cnt[15:8]; b[5] = cnt[7:0];
        b[6] = x[23:16]; b[7] = x[15:8]; b[8] = x[7:0];
        s = '0;
        for (int i = 1; i < 9; i++) s = s + b[i];
        b[9] = bad ? s + 8'd1 : s;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk); in_valid = 1'b1; in_byte = b[i];
        end
        @(negedge clk); in_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic verdict(input string req, input logic ea, input logic er);
        check(req, "acc_stb", 64'(acc_stb), 64'(ea));
        check(req, "rej_stb", 64'(rej_stb), 64'(er));
        if (ea) exp_acc_n++;
        if (er) exp_rej_n++;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        @(negedge clk);
        check("R11", "locked after reset", 64'(locked), 64'd0);
        check("R11", "acc_total after reset", 64'(acc_total), 64'd0);

        // Table walk: R2 R3 R4 R5 R7 R8 R9 R10
        for (int v = 0; v < NV; v++) begin
            send(VEC[v].core, VEC[v].cnt, VEC[v].x, VEC[v].bad);
            verdict("R3", VEC[v].acc, VEC[v].rej);
            check("R7", "locked", 64'(locked), 64'(VEC[v].lock));
            check("R8", "anomaly", 64'(anomaly), 64'(VEC[v].anom));
            if (VEC[v].acc) begin
                check("R10", "acc_core", 64'(acc_core), 64'(VEC[v].core));
                check("R10", "acc_cnt", 64'(acc_cnt), 64'(VEC[v].cnt));
                check("R10", "acc_x", 64'(acc_x), 64'(VEC[v].x));
            end
            @(negedge clk);
            check("R10", "strobes one cycle", 64'(acc_stb | rej_stb), 64'd0);
        end
        check("R9", "acc_total", 64'(acc_total), 64'(exp_acc_n));
        check("R9", "rej_total", 64'(rej_total), 64'(exp_rej_n));

        // R1: junk before the sync byte is ignored
        @(negedge clk); in_valid = 1'b1; in_byte = 8'h00;
        @(negedge clk); in_byte = 8'h37;
        send(8'd1, 32'd398, 24'h010203, 1'b0);
        verdict("R1", 1'b1, 1'b0);

        // R6: out-of-range core index rejected, core 48 untouched
        send(8'd49, 32'h01000041, 24'h0, 1'b0);
        verdict("R6", 1'b0, 1'b1);
        send(8'd48, 32'h01000041, 24'h0, 1'b0);
        verdict("R6", 1'b1, 1'b0);
        check("R9", "rej_total", 64'(rej_total), 64'(exp_rej_n));

        // R11: reset clears flags, totals and valid bits
        do_reset();
        @(negedge clk);
        check("R11", "locked", 64'(locked), 64'd0);
        check("R11", "anomaly", 64'(anomaly), 64'd0);
        check("R11", "rej_total", 64'(rej_total), 64'd0);
        exp_acc_n = 0; exp_rej_n = 0;
        send(8'd0, 32'd248, 24'h0, 1'b0);
        verdict("R11", 1'b0, 1'b1);

        // R7: a reject between accepts delays lock; pre-lock rejects set no anomaly (R8)
        send(8'd1, 32'd500, 24'h0, 1'b0);
        verdict("R7", 1'b0, 1'b1);
        send(8'd0, 32'd297, 24'h0, 1'b0);
        verdict("R7", 1'b1, 1'b0);
        send(8'd1, 32'd600, 24'h0, 1'b0);
        verdict("R5", 1'b0, 1'b1);
        send(8'd0, 32'd346, 24'h0, 1'b0);
        verdict("R7", 1'b1, 1'b0);
        check("R7", "no lock after split accepts", 64'(locked), 64'd0);
        check("R8", "no anomaly before lock", 64'(anomaly), 64'd0);
        send(8'd1, 32'd649, 24'h0, 1'b0);
        verdict("R5", 1'b1, 1'b0);
        check("R7", "lock on back-to-back accepts", 64'(locked), 64'd1);
        check("R9", "acc_total", 64'(acc_total), 64'(exp_acc_n));
        check("R9", "rej_total", 64'(rej_total), 64'(exp_rej_n));

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule